// File: doc/BRIEF.md
# Linked Dual-Channel Calibration Registers

This block holds calibration trim values for a set of two-channel converter instances. Each instance has an offset trim and a gain trim for each of its two channels. A simple synchronous register bus loads and reads the trims. The bus has a byte address, write data, a write strobe and registered read data. Every trim is also driven out continuously on parallel output vectors, so the converter datapath always sees the current values.

Older software may calibrate only channel 0. To support it, each channel-0/channel-1 register pair has a link. While the link is intact, a write to the channel-0 register also stores the same value into its channel-1 partner. The first direct write to the channel-1 register breaks that pair's link. After that, channel 0 and channel 1 are independent until the next reset. Each pair keeps its own link: the offset pair and the gain pair of every instance are separate.

Top module: `cal_link_regs`

## Requirements
- R1: After reset every trim register reads 0x00, every pair is linked, and the read data is 0x00.
- R2: Mapped byte addresses are 0 to 4*NUM_INST-1. Address bit 0 selects the channel (0 or 1), bit 1 selects the kind (0 offset, 1 gain), and the bits above select the instance. A write to a mapped address stores the write data in that register.
- R3: While a pair is linked, a write to its channel-0 register stores the same value in its channel-1 register.
- R4: A write to a channel-1 register changes only that register and breaks the link of its pair.
- R5: After a pair's link is broken, writes to its channel-0 register leave its channel-1 register unchanged.
- R6: Links are independent. Breaking the offset link of one instance leaves the gain link of that instance and the links of all other instances intact.
- R7: Reset restores every link and clears every register.
- R8: Writes to unmapped addresses change no register and no link.
- R9: The read data presents, one cycle after the address, the value of the addressed register, or 0x00 for an unmapped address. Reads never change a register or a link.
- R10: The parallel outputs show a written value from the clock edge that accepts the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | DATA_W | Write data |
| bus_we | input | 1 | Write strobe |
| bus_rdata | output | DATA_W | Registered read data |
| off_ch0_o | output | NUM_INST*DATA_W | Channel-0 offset trims, instance i at bits [i*DATA_W +: DATA_W] |
| off_ch1_o | output | NUM_INST*DATA_W | Channel-1 offset trims |
| gain_ch0_o | output | NUM_INST*DATA_W | Channel-0 gain trims |
| gain_ch1_o | output | NUM_INST*DATA_W | Channel-1 gain trims |

## Verification
The assertions assume that the bus offers at most one write per cycle. That lets the decoder assume that a pair never sees its channel-0 and channel-1 strobes together. They also assume that the strobe and address are clean whenever reset is low. The stimulus drives exactly one address and strobe per cycle. It changes them only on the falling edge, and it spreads random addresses over twice the mapped range, so that unmapped writes and reads appear without breaking either assumption.

// File: rtl/cal_link_pkg.sv
package cal_link_pkg;

  // Register kind selected by address bit 1
  typedef enum logic {
    KIND_OFFSET = 1'b0,
    KIND_GAIN   = 1'b1
  } cal_kind_e;

  // Channel selected by address bit 0
  typedef enum logic {
    CHAN_PRIMARY   = 1'b0,
    CHAN_SECONDARY = 1'b1
  } cal_chan_e;

  // Pair index from instance and kind
  function automatic int unsigned pair_index(input int unsigned inst, input cal_kind_e kind);
    return inst * 2 + int'(kind);
  endfunction

endpackage

// File: rtl/cal_wr_decode.sv
module cal_wr_decode #(
  parameter int ADDR_W    = 8,
  parameter int NUM_PAIRS = 4
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [ADDR_W-1:0]    addr,
  input  logic                 we,
  output logic                 mapped_o,
  output logic [NUM_PAIRS-1:0] wr0_o,
  output logic [NUM_PAIRS-1:0] wr1_o
);
  localparam int MAP_SIZE = NUM_PAIRS * 2;
  localparam int SEL_W    = $clog2(MAP_SIZE);
  localparam int PW       = (SEL_W > 1) ? SEL_W - 1 : 1;

  logic [PW-1:0] pidx;
  logic          hit;

  assign mapped_o = (addr < ADDR_W'(MAP_SIZE));
  assign pidx     = addr[SEL_W-1:1];
  assign hit      = we && mapped_o;

  for (genvar p = 0; p < NUM_PAIRS; p++) begin : g_pair_sel
    assign wr0_o[p] = hit && (pidx == PW'(p)) && (addr[0] == cal_link_pkg::CHAN_PRIMARY);
    assign wr1_o[p] = hit && (pidx == PW'(p)) && (addr[0] == cal_link_pkg::CHAN_SECONDARY);
  end

  // R2
  single_strobe_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({wr0_o, wr1_o}));

  // R8
  unmapped_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !mapped_o |-> ({wr0_o, wr1_o} == '0));

endmodule

// File: rtl/cal_pair.sv
module cal_pair #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr0_i,
  input  logic              wr1_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] ch0_q,
  output logic [DATA_W-1:0] ch1_q,
  output logic              linked_q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      ch0_q    <= '0;
      ch1_q    <= '0;
      linked_q <= 1'b1;
    end else begin
      if (wr0_i) begin
        ch0_q <= wdata_i;
        if (linked_q) ch1_q <= wdata_i;
      end
      if (wr1_i) begin
        ch1_q    <= wdata_i;
        linked_q <= 1'b0;
      end
    end
  end

  // R3
  mirror_chk: assert property (@(posedge clk) disable iff (rst)
    (wr0_i && !wr1_i && linked_q) |=> (ch1_q == $past(wdata_i)) && (ch0_q == $past(wdata_i)));

  // R4
  direct_break_chk: assert property (@(posedge clk) disable iff (rst)
    (wr1_i && !wr0_i) |=> !linked_q && (ch1_q == $past(wdata_i)) && $stable(ch0_q));

  // R5
  unlinked_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (wr0_i && !wr1_i && !linked_q) |=> $stable(ch1_q));

  // R7
  link_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    !linked_q |=> !linked_q);

  // R9
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!wr0_i && !wr1_i) |=> $stable(ch0_q) && $stable(ch1_q) && $stable(linked_q));

endmodule

// File: rtl/cal_rd_mux.sv
module cal_rd_mux #(
  parameter int ADDR_W    = 8,
  parameter int DATA_W    = 8,
  parameter int NUM_PAIRS = 4
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic [ADDR_W-1:0]           addr,
  input  logic                        mapped_i,
  input  logic [NUM_PAIRS*DATA_W-1:0] ch0_i,
  input  logic [NUM_PAIRS*DATA_W-1:0] ch1_i,
  output logic [DATA_W-1:0]           rdata_o
);
  localparam int SEL_W = $clog2(NUM_PAIRS * 2);
  localparam int PW    = (SEL_W > 1) ? SEL_W - 1 : 1;

  logic [PW-1:0]     pidx;
  logic [DATA_W-1:0] sel_val;

  assign pidx = addr[SEL_W-1:1];

  always_comb begin
    sel_val = '0;
    for (int p = 0; p < NUM_PAIRS; p++) begin
      if (pidx == PW'(p)) begin
        sel_val = addr[0] ? ch1_i[p*DATA_W +: DATA_W] : ch0_i[p*DATA_W +: DATA_W];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst)           rdata_o <= '0;
    else if (mapped_i) rdata_o <= sel_val;
    else               rdata_o <= '0;
  end

  // R9
  unmapped_zero_chk: assert property (@(posedge clk) disable iff (rst)
    !mapped_i |=> (rdata_o == '0));

endmodule

// File: rtl/cal_link_regs.sv
module cal_link_regs #(
  parameter int DATA_W   = 8,
  parameter int NUM_INST = 2,
  parameter int ADDR_W   = 8
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [ADDR_W-1:0]          bus_addr,
  input  logic [DATA_W-1:0]          bus_wdata,
  input  logic                       bus_we,
  output logic [DATA_W-1:0]          bus_rdata,
  output logic [NUM_INST*DATA_W-1:0] off_ch0_o,
  output logic [NUM_INST*DATA_W-1:0] off_ch1_o,
  output logic [NUM_INST*DATA_W-1:0] gain_ch0_o,
  output logic [NUM_INST*DATA_W-1:0] gain_ch1_o
);
  import cal_link_pkg::*;

  localparam int NUM_PAIRS = NUM_INST * 2;

  logic                        mapped;
  logic [NUM_PAIRS-1:0]        wr0;
  logic [NUM_PAIRS-1:0]        wr1;
  logic [NUM_PAIRS-1:0]        linked;
  logic [NUM_PAIRS*DATA_W-1:0] ch0_all;
  logic [NUM_PAIRS*DATA_W-1:0] ch1_all;

  cal_wr_decode #(.ADDR_W(ADDR_W), .NUM_PAIRS(NUM_PAIRS)) u_dec (
    .clk      (clk),
    .rst      (rst),
    .addr     (bus_addr),
    .we       (bus_we),
    .mapped_o (mapped),
    .wr0_o    (wr0),
    .wr1_o    (wr1)
  );

  for (genvar i = 0; i < NUM_INST; i++) begin : g_inst
    for (genvar k = 0; k < 2; k++) begin : g_kind
      localparam int P = i * 2 + k;

      cal_pair #(.DATA_W(DATA_W)) u_pair (
        .clk      (clk),
        .rst      (rst),
        .wr0_i    (wr0[P]),
        .wr1_i    (wr1[P]),
        .wdata_i  (bus_wdata),
        .ch0_q    (ch0_all[P*DATA_W +: DATA_W]),
        .ch1_q    (ch1_all[P*DATA_W +: DATA_W]),
        .linked_q (linked[P])
      );

      if (k == int'(KIND_OFFSET)) begin : g_off
        assign off_ch0_o[i*DATA_W +: DATA_W] = ch0_all[P*DATA_W +: DATA_W];
        assign off_ch1_o[i*DATA_W +: DATA_W] = ch1_all[P*DATA_W +: DATA_W];
      end else begin : g_gain
        assign gain_ch0_o[i*DATA_W +: DATA_W] = ch0_all[P*DATA_W +: DATA_W];
        assign gain_ch1_o[i*DATA_W +: DATA_W] = ch1_all[P*DATA_W +: DATA_W];
      end
    end
  end

  cal_rd_mux #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_PAIRS(NUM_PAIRS)) u_rd (
    .clk      (clk),
    .rst      (rst),
    .addr     (bus_addr),
    .mapped_i (mapped),
    .ch0_i    (ch0_all),
    .ch1_i    (ch1_all),
    .rdata_o  (bus_rdata)
  );

  // R1
  reset_state_chk: assert property (@(posedge clk)
    rst |=> (ch0_all == '0) && (ch1_all == '0) && (&linked) && (bus_rdata == '0));

  // R6
  one_link_drop_chk: assert property (@(posedge clk) disable iff (rst)
    $countones($past(linked) & ~linked) <= 1);

endmodule

// File: tb/cal_link_regs_test.sv
module cal_link_regs_test;
  localparam int DW = 8;
  localparam int NI = 2;
  localparam int AW = 8;
  localparam int NREG = NI * 4;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic          we = 1'b0;
  logic          rd_req = 1'b0;
  logic          rd_req_d = 1'b0;
  logic [DW-1:0] rdata;
  logic [NI*DW-1:0] oc0, oc1, gc0, gc1;

  int tests = 0;
  int fails = 0;

  logic [DW-1:0] model [NREG];
  logic          lnk   [NREG/2];
  logic [DW-1:0] exp_q [$];
  string         tag_q [$];

  cal_link_regs #(.DATA_W(DW), .NUM_INST(NI), .ADDR_W(AW)) uut (
    .clk(clk), .rst(rst), .bus_addr(addr), .bus_wdata(wdata), .bus_we(we),
    .bus_rdata(rdata), .off_ch0_o(oc0), .off_ch1_o(oc1),
    .gain_ch0_o(gc0), .gain_ch1_o(gc1)
  );

  always #10 clk = ~clk;

  always @(posedge clk) rd_req_d <= rd_req;

  // Scoreboard monitor: compares read data one cycle after the request
  always @(negedge clk) begin
    if (rd_req_d && exp_q.size() > 0) begin
      logic [DW-1:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      tests++;
      if (rdata !== e) begin
        fails++;
        $display("FAIL %s: rdata actual %02h expected %02h", t, rdata, e);
      end
    end
  end

  function automatic logic [DW-1:0] out_of(input int a);
    int i, k, c;
    i = a / 4; k = (a / 2) % 2; c = a % 2;
    if (k == 0) return c ? oc1[i*DW +: DW] : oc0[i*DW +: DW];
    return c ? gc1[i*DW +: DW] : gc0[i*DW +: DW];
  endfunction

  task automatic model_reset();
    for (int r = 0; r < NREG; r++) model[r] = '0;
    for (int p = 0; p < NREG/2; p++) lnk[p] = 1'b1;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; we = 1'b0; rd_req = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
    model_reset();
  endtask

  task automatic wr(input int a, input logic [DW-1:0] d);
    @(negedge clk);
    addr = AW'(a); wdata = d; we = 1'b1; rd_req = 1'b0;
    if (a < NREG) begin
      if (a % 2 == 0) begin
        model[a] = d;
        if (lnk[a/2]) model[a+1] = d;
      end else begin
        model[a] = d;
        lnk[a/2] = 1'b0;
      end
    end
  endtask

  task automatic rd(input int a, input string t);
    @(negedge clk);
    addr = AW'(a); we = 1'b0; rd_req = 1'b1;
    exp_q.push_back((a < NREG) ? model[a] : '0);
    tag_q.push_back(t);
  endtask

  task automatic idle();
    @(negedge clk);
    we = 1'b0; rd_req = 1'b0;
  endtask

  task automatic check_outs(input string t);
    idle();
    for (int r = 0; r < NREG; r++) begin
      tests++;
      if (out_of(r) !== model[r]) begin
        fails++;
        $display("FAIL %s: reg %0d actual %02h expected %02h", t, r, out_of(r), model[r]);
      end
    end
  endtask

  initial begin
    #(20 * 150000);
    tests++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    model_reset();
    do_reset();
    // R1: reset contents on outputs and read port
    check_outs("R1");
    for (int a = 0; a < NREG; a++) rd(a, "R1");
    idle();

    // R2 R3 R10: channel-0 writes mirror on every pair
    wr(0, 8'h11); wr(2, 8'h22); wr(4, 8'h44); wr(6, 8'h66);
    check_outs("R3");
    // R4: direct channel-1 write leaves channel 0 and breaks offset link of instance 0
    wr(1, 8'h33);
    check_outs("R4");
    // R5: channel-0 write no longer reaches channel 1
    wr(0, 8'h5A);
    check_outs("R5");
    // R6: gain pair of instance 0 and offset of instance 1 still linked
    wr(2, 8'hA5); wr(4, 8'hC3);
    check_outs("R6");
    // R8: unmapped writes ignored
    wr(8, 8'h99); wr(255, 8'h77); wr(13, 8'h12);
    check_outs("R8");
    // R9: unmapped reads yield zero; reads leave links intact
    rd(8, "R9"); rd(200, "R9");
    rd(3, "R9"); rd(7, "R9"); rd(5, "R9");
    wr(6, 8'hE1);
    check_outs("R9");
    for (int a = 0; a < NREG; a++) rd(a, "R2");
    idle();
    // R10: back-to-back writes visible the following cycle
    wr(7, 8'h0F); wr(6, 8'hF0);
    check_outs("R10");

    // R7: reset restores links
    do_reset();
    check_outs("R7");
    wr(0, 8'h3C); wr(6, 8'hC3);
    check_outs("R7");

    // Random mix over mapped and unmapped addresses
    for (int n = 0; n < 400; n++) begin
      int a;
      a = $urandom_range(0, 2*NREG - 1);
      if ($urandom_range(0, 2) == 0) rd(a, "R9");
      else wr(a, DW'($urandom));
      if (n % 25 == 24) check_outs("R5");
    end
    idle(); idle();
    check_outs("R2");

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule